// File: doc/BRIEF.md
# Spread Spectrum Modulation Sequencer

This block produces a periodic, symmetric signed offset that is added to a PLL feedback divide value to spread the output clock spectrum. It runs on the phase detector clock. A small array of unsigned delta samples describes one quarter of the modulation waveform. The block walks those samples forward and backward, adding or subtracting each one, so that the four quarters mirror each other. At the end of every period the running sum is back at zero.

Two fields control the timing. The step field sets how many detector cycles pass between waveform steps. The sample-count field sets how many samples make up one quarter. Together they fix the modulation frequency. A step field of zero turns modulation off. Any other value outside the legal window also turns modulation off and raises an error flag. A programmable base offset is added to the running sum before the value is driven out.

Top module: `ssc_sequencer`

## Requirements
- R1: When `step_sel_i` is 0, `ofs_o` is 0 one cycle later and stays 0, and `cfg_err_o` is 0.
- R2: With a legal `step_sel_i` value T (5 to 14), the waveform advances once every T clock cycles, and `ofs_o` holds its value between two steps.
- R3: A value of `step_sel_i` in 1..4 or equal to 15 sets `cfg_err_o` to 1 one cycle later and forces `ofs_o` to 0. Any legal value or 0 gives `cfg_err_o` = 0 one cycle later.
- R4: One quarter holds `samp_cnt_i`+1 samples. Sample k is the unsigned byte `deltas_i[8k+7:8k]`.
- R5: For the step with zero-based number s inside a period, let q = s/(N) and i = s mod N, where N is the number of samples. In quarter q=0 the block adds sample i. In q=1 it subtracts sample N-1-i. In q=2 it subtracts sample i. In q=3 it adds sample N-1-i.
- R6: After the last step of each period (step 4N) the running sum is 0, so `ofs_o` equals the base offset. The sequence then repeats.
- R7: `ofs_o` equals `base_ofs_i` plus the running sum. `base_ofs_i` is taken only at a step or at a restart. A change of `base_ofs_i` between steps has no effect until the next step.
- R8: On any change of `step_sel_i` or `samp_cnt_i` to a legal configuration, the running sum is cleared and `ofs_o` becomes `base_ofs_i` on the next clock. The first step follows T cycles later, starting at quarter 0, sample 0.
- R9: While `rst_ni` is low, `ofs_o` is 0 and `cfg_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase detector rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_sel_i | input | 4 | Detector cycles per modulation step. 0 disables modulation; only 5..14 are legal |
| samp_cnt_i | input | 3 | Samples per quarter, minus one |
| deltas_i | input | 64 | Eight unsigned 8-bit delta samples; sample k is at bits 8k+7:8k |
| base_ofs_i | input | 12 | Signed base offset added to the running sum |
| ofs_o | output | 12 | Signed offset to apply to the feedback divider |
| cfg_err_o | output | 1 | Registered flag for an illegal nonzero step value |

## Verification
A wrong quarter or a wrong index gives the wrong sample magnitude or the wrong sign. This shows at `ofs_o` on the very step where the error occurs. The bench compares every step of more than one full period for several step and sample-count settings, so it catches that step. A tick counter that runs off by one moves the change of `ofs_o` by one cycle. The bench therefore checks the cycle just before each step as well as the step itself. An accumulator that does not return to zero shows as an offset other than the base at the end of a period, and that error then carries into every later step.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    Q_ADD_FWD = 2'd0,
    Q_SUB_REV = 2'd1,
    Q_SUB_FWD = 2'd2,
    Q_ADD_REV = 2'd3
  } quad_e;
endpackage

// File: rtl/ssc_step_timer.sv
module ssc_step_timer #(
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [STEP_W-1:0] period_i,
  output logic              step_o
);
  logic [STEP_W-1:0] cnt_q;

  assign step_o = !clr_i && (cnt_q == period_i - STEP_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + STEP_W'(1);
  end

  // R2: counter never passes the programmed period
  a_r2_cnt_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> cnt_q < period_i);
endmodule

// File: rtl/ssc_walker.sv
module ssc_walker
  import ssc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] last_idx_i,
  output logic [IDX_W-1:0] sel_o,
  output logic             sub_o,
  output logic             end_o
);
  quad_e            quad_q;
  logic [IDX_W-1:0] idx_q;
  logic             rev;

  assign rev   = (quad_q == Q_SUB_REV) || (quad_q == Q_ADD_REV);
  assign sub_o = (quad_q == Q_SUB_REV) || (quad_q == Q_SUB_FWD);
  assign sel_o = rev ? (last_idx_i - idx_q) : idx_q;
  assign end_o = (quad_q == Q_ADD_REV) && (idx_q == last_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quad_q <= Q_ADD_FWD;
      idx_q  <= '0;
    end else if (clr_i) begin
      quad_q <= Q_ADD_FWD;
      idx_q  <= '0;
    end else if (step_i) begin
      if (idx_q == last_idx_i) begin
        idx_q  <= '0;
        quad_q <= quad_e'(quad_q + 2'd1);
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  // R4: sample index stays within the programmed quarter length
  a_r4_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> idx_q <= last_idx_i);
  // R5: leaving the last quarter returns to the first one
  a_r5_quad_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && step_i && end_o) |=> (quad_q == Q_ADD_FWD && idx_q == '0));
endmodule

// File: rtl/ssc_accum.sv
module ssc_accum #(
  parameter int DELTA_W = 8,
  parameter int OFS_W   = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    clr_i,
  input  logic                    step_i,
  input  logic                    sub_i,
  input  logic [DELTA_W-1:0]      delta_i,
  input  logic signed [OFS_W-1:0] base_i,
  output logic signed [OFS_W-1:0] ofs_o,
  output logic signed [OFS_W-1:0] acc_o
);
  logic signed [OFS_W-1:0] acc_q, acc_nx, dx;

  assign dx     = $signed({{(OFS_W-DELTA_W){1'b0}}, delta_i});
  assign acc_nx = sub_i ? (acc_q - dx) : (acc_q + dx);
  assign acc_o  = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ofs_o <= '0;
    end else if (!en_i) begin
      acc_q <= '0;
      ofs_o <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      ofs_o <= base_i;
    end else if (step_i) begin
      acc_q <= acc_nx;
      ofs_o <= base_i + acc_nx;
    end
  end

  // R7: output only moves on a step, a restart or a disable
  a_r7_hold_between_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !step_i) |=> $stable(ofs_o));
endmodule

// File: rtl/ssc_sequencer.sv
module ssc_sequencer #(
  parameter int STEP_W   = 4,
  parameter int MIN_STEP = 5,
  parameter int MAX_STEP = 14,
  parameter int MAX_SAMP = 8,
  parameter int DELTA_W  = 8,
  parameter int OFS_W    = 12
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [STEP_W-1:0]                 step_sel_i,
  input  logic [$clog2(MAX_SAMP)-1:0]       samp_cnt_i,
  input  logic [MAX_SAMP*DELTA_W-1:0]       deltas_i,
  input  logic signed [OFS_W-1:0]           base_ofs_i,
  output logic signed [OFS_W-1:0]           ofs_o,
  output logic                              cfg_err_o
);
  localparam int IDX_W = $clog2(MAX_SAMP);

  logic                    en, bad, chg, clr, step, sub, pend;
  logic [IDX_W-1:0]        sel;
  logic [STEP_W-1:0]       step_q;
  logic [IDX_W-1:0]        samp_q;
  logic [DELTA_W-1:0]      delta;
  logic signed [OFS_W-1:0] acc;

  assign en    = (step_sel_i >= STEP_W'(MIN_STEP)) && (step_sel_i <= STEP_W'(MAX_STEP));
  assign bad   = (step_sel_i != '0) && !en;
  assign chg   = (step_sel_i != step_q) || (samp_cnt_i != samp_q);
  assign clr   = !en || chg;
  assign delta = deltas_i[sel*DELTA_W +: DELTA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q    <= '0;
      samp_q    <= '0;
      cfg_err_o <= 1'b0;
    end else begin
      step_q    <= step_sel_i;
      samp_q    <= samp_cnt_i;
      cfg_err_o <= bad;
    end
  end

  ssc_step_timer #(.STEP_W(STEP_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .period_i(step_sel_i),
    .step_o  (step)
  );

  ssc_walker #(.IDX_W(IDX_W)) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .step_i    (step),
    .last_idx_i(samp_cnt_i),
    .sel_o     (sel),
    .sub_o     (sub),
    .end_o     (pend)
  );

  ssc_accum #(.DELTA_W(DELTA_W), .OFS_W(OFS_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .clr_i  (chg),
    .step_i (step),
    .sub_i  (sub),
    .delta_i(delta),
    .base_i (base_ofs_i),
    .ofs_o  (ofs_o),
    .acc_o  (acc)
  );

  // R1: disabled gives zero offset
  a_r1_off_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_sel_i == '0) |=> (ofs_o == '0 && !cfg_err_o));
  // R3: illegal nonzero step flags error and zeroes output
  a_r3_bad_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> (cfg_err_o && ofs_o == '0));
  // R6: sum is back at zero at each period end
  a_r6_period_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !chg && step && pend) |=> (acc == '0));
  // R8: legal config change loads base with cleared sum
  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && chg) |=> (acc == '0 && ofs_o == $past(base_ofs_i)));
endmodule

// File: tb/ssc_sequencer_tb_top.sv
`timescale 1ns/1ps
module ssc_sequencer_tb_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        tssc = 4'd0;
  logic [2:0]        nssc = 3'd0;
  logic signed [11:0] base = 12'sd0;
  logic signed [11:0] ofs;
  logic              err;
  int                n_chk = 0;
  int                n_bad = 0;

  // slot0=5 slot1=3 slot2=7 slot3=2 slot4=9 slot5=1 slot6=4 slot7=6
  localparam logic [63:0] DELTAS = {8'd6, 8'd4, 8'd1, 8'd9, 8'd2, 8'd7, 8'd3, 8'd5};
  // {tssc[3:0], nssc[2:0], base[11:0]}
  localparam logic [18:0] VEC [4] = '{
    {4'd5,  3'd3, 12'sd0},
    {4'd14, 3'd0, 12'sd100},
    {4'd7,  3'd7, -12'sd50},
    {4'd9,  3'd2, -12'sd20}
  };

  always #5 clk = ~clk;

  ssc_sequencer dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .step_sel_i(tssc),
    .samp_cnt_i(nssc),
    .deltas_i  (DELTAS),
    .base_ofs_i(base),
    .ofs_o     (ofs),
    .cfg_err_o (err)
  );

  function automatic int dlt(input int k);
    return int'(DELTAS[k*8 +: 8]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t, n, b, acc, q, i, j;
    repeat (3) @(negedge clk);
    chk("R9 reset ofs", int'(ofs), 0);
    chk("R9 reset err", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: full period plus one step, every step and the cycle before it
    for (int v = 0; v < 4; v++) begin
      t = int'(VEC[v][18:15]);
      n = int'(VEC[v][14:12]) + 1;
      b = int'($signed(VEC[v][11:0]));
      tssc = VEC[v][18:15];
      nssc = VEC[v][14:12];
      base = $signed(VEC[v][11:0]);
      @(negedge clk);
      chk("R8 restart to base", int'(ofs), b);
      chk("R3 legal no err", int'(err), 0);
      acc = 0;
      for (int s = 0; s < 4*n + 1; s++) begin
        repeat (t - 1) @(negedge clk);
        chk("R2 hold before step", int'(ofs), b + acc);
        @(negedge clk);
        q = (s / n) % 4;
        i = s % n;
        j = (q == 1 || q == 3) ? n - 1 - i : i;
        acc += (q == 1 || q == 2) ? -dlt(j) : dlt(j);
        chk("R5 R4 step value", int'(ofs), b + acc);
        if (s == 4*n - 1) chk("R6 period end at base", int'(ofs), b);
      end
    end

    // R7: base change between steps
    tssc = 4'd6; nssc = 3'd1; base = 12'sd10;
    @(negedge clk);
    chk("R8 restart", int'(ofs), 10);
    repeat (6) @(negedge clk);
    chk("R2 first step", int'(ofs), 15);
    base = -12'sd30;
    @(negedge clk);
    chk("R7 base ignored mid step", int'(ofs), 15);
    repeat (4) @(negedge clk);
    chk("R7 base ignored before step", int'(ofs), 15);
    @(negedge clk);
    chk("R7 new base at step", int'(ofs), -30 + 5 + 3);

    // R8: restart mid sequence on sample count change
    nssc = 3'd2;
    @(negedge clk);
    chk("R8 restart mid run", int'(ofs), -30);
    repeat (6) @(negedge clk);
    chk("R8 first step from sample 0", int'(ofs), -25);

    // R1: disabled
    tssc = 4'd0;
    @(negedge clk);
    chk("R1 off ofs", int'(ofs), 0);
    chk("R1 off err", int'(err), 0);
    repeat (10) @(negedge clk);
    chk("R1 stays zero", int'(ofs), 0);

    // R3: illegal values
    tssc = 4'd3;
    @(negedge clk);
    chk("R3 tssc 3 err", int'(err), 1);
    chk("R3 tssc 3 ofs", int'(ofs), 0);
    tssc = 4'd15;
    @(negedge clk);
    chk("R3 tssc 15 err", int'(err), 1);
    repeat (20) @(negedge clk);
    chk("R3 tssc 15 ofs", int'(ofs), 0);
    tssc = 4'd4;
    @(negedge clk);
    chk("R3 tssc 4 err", int'(err), 1);
    tssc = 4'd14;
    @(negedge clk);
    chk("R3 legal clears err", int'(err), 0);
    chk("R8 enable restarts", int'(ofs), -30);
    repeat (14) @(negedge clk);
    chk("R2 step after 14", int'(ofs), -25);

    // R9: reset in mid run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset ofs mid run", int'(ofs), 0);
    chk("R9 reset err mid run", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end
endmodule